// File: doc/BRIEF.md
# Two-Wire EEPROM Block Transfer Sequencer

This block turns one block-read or block-write request into the series of byte commands that a lower-level two-wire byte engine executes on the bus. A request carries a direction, a 7-bit device address, an 8-bit offset inside the device and a byte count. It also carries a legacy flag. In normal mode the device address and the offset go out as two separate bytes. In legacy mode the offset is folded into the single address byte, for parts that answer to every device code.

A read sends the device address and then the offset. After a forced bus-free pause it issues a repeated START with the read address and clocks the data out back to back. Read bytes leave on a valid-only stream. A write pulls its data from a valid/ready stream and splits the transfer into chunks of at most `CHUNK_MAX` bytes, each closed by a STOP. After each chunk the block polls the device with read-address probes until one is acknowledged, then discards one dummy byte. A missing acknowledge on any written byte ends the transfer early, and so does an exhausted poll budget. The early end issues a STOP command and then reports done together with error.

The byte engine receives one command at a time. `eng_go` pulses for one cycle while the command fields are valid, and the fields then stay unchanged until the engine answers with a one-cycle `eng_done`.

Top module: `eeprom_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `error_o`, `rd_valid_o`, `wd_ready_o` and `eng_go` are all low.
- R2: A request with length 0 issues no engine command and produces a one-cycle `done_o` with `error_o` low.
- R3: A normal-mode read issues, in order: write-byte (op 0) with start and data {dev,0}; write-byte with the offset; write-byte with start and data {dev,1}; then one read-byte command (op 1) per requested byte.
- R4: In a normal-mode read, at least `BUF_WAIT` clock cycles pass between `eng_done` for the offset byte and `eng_go` of the repeated START.
- R5: A legacy-mode read issues a single write-byte with start and data {offset[6:0],1} and then goes straight to the data reads.
- R6: Every read-byte command acknowledges except the last one, which has both `eng_nack` and `eng_stop` set. Each received byte appears once on `rd_data_o`/`rd_valid_o`, in bus order.
- R7: A write is split into chunks of min(remaining, `CHUNK_MAX`) bytes. Each chunk opens with write-byte start {dev,0} and then the offset, or in legacy mode a single start {offset[6:0],0}. The offset used is the request offset plus the bytes already written. The chunk's last data byte carries `eng_stop`, and data bytes come from `wd_data_i` in stream order.
- R8: After each write chunk, write-byte start {dev,1} probes are repeated until one is acknowledged. A read-byte with nack and stop then follows, and its data is not delivered on the read stream.
- R9: If `POLL_MAX` consecutive probes of one chunk are not acknowledged, the transfer aborts after exactly `POLL_MAX` probes. An acknowledge on the final permitted probe counts as success.
- R10: A missing acknowledge on any write-byte that is not a probe (device address, offset or data) aborts the transfer at once.
- R11: An abort issues one stop-only command (op 2) and then raises `done_o` together with `error_o`. `error_o` is never high without `done_o`.
- R12: After `eng_go` the sequencer issues no further `eng_go`, and holds the command fields, until `eng_done` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Start a transfer; taken when `busy_o` is low |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_legacy_i | input | 1 | Offset carried in the address byte |
| req_dev_i | input | 7 | Device address |
| req_offset_i | input | 8 | Starting offset inside the device |
| req_len_i | input | LEN_W | Byte count |
| busy_o | output | 1 | Transfer in progress |
| wd_data_i | input | 8 | Write data byte |
| wd_valid_i | input | 1 | Write data present |
| wd_ready_o | output | 1 | Write byte is taken this cycle when valid |
| rd_data_o | output | 8 | Read data byte |
| rd_valid_o | output | 1 | Read byte strobe |
| done_o | output | 1 | One-cycle end of transfer |
| error_o | output | 1 | Transfer aborted; valid with `done_o` |
| eng_go | output | 1 | Command strobe to the byte engine |
| eng_op | output | 2 | 0 write byte, 1 read byte, 2 stop only |
| eng_start | output | 1 | Precede the byte with START |
| eng_stop | output | 1 | Follow the byte with STOP |
| eng_nack | output | 1 | Read byte: answer NACK instead of ACK |
| eng_byte | output | 8 | Byte to send |
| eng_done | input | 1 | Engine finished the command |
| eng_ack | input | 1 | Sent byte was acknowledged |
| eng_rxbyte | input | 8 | Byte received by a read command |

## Verification
The poll budget running out and the device finally acknowledging can land on the same probe, the last permitted one. That probe must resolve as success, not abort. The bench makes the responder refuse exactly `POLL_MAX-1` probes and expects a clean finish with a dummy read. It then refuses `POLL_MAX` probes and expects exactly `POLL_MAX` probes followed by a stop-only command and an error. Around these cases, sweeps over every length from 0 to 9 in both modes and both directions compare the full command log with a sequence built in the bench from the requirements.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        ENG_WR   = 2'd0,
        ENG_RD   = 2'd1,
        ENG_STOP = 2'd2
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP,
        ST_FIN
    } seq_st_e;

    typedef enum logic [3:0] {
        PH_LEG,
        PH_DEVW,
        PH_OFFS,
        PH_DEVR,
        PH_RDAT,
        PH_WDAT,
        PH_POLL,
        PH_DUMMY,
        PH_ABORT
    } seq_ph_e;

    typedef struct packed {
        eng_op_e    op;
        logic       start;
        logic       stop;
        logic       nack;
        logic [7:0] data;
    } eng_cmd_t;

endpackage

// File: rtl/xfer_downcnt.sv
module xfer_downcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (dec_i)
            cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/xfer_chunk_sel.sv
module xfer_chunk_sel #(
    parameter int LEN_W     = 8,
    parameter int CHUNK_MAX = 4,
    parameter int CK_W      = 3
) (
    input  logic [LEN_W-1:0] left_i,
    output logic [CK_W-1:0]  chunk_o
);

    always_comb begin
        if (left_i >= LEN_W'(CHUNK_MAX))
            chunk_o = CK_W'(CHUNK_MAX);
        else
            chunk_o = CK_W'(left_i);
    end

endmodule

// File: rtl/eeprom_xfer_seq.sv
module eeprom_xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int CHUNK_MAX = 4,
    parameter int BUF_WAIT  = 7500,
    parameter int POLL_MAX  = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             req_legacy_i,
    input  logic [6:0]       req_dev_i,
    input  logic [7:0]       req_offset_i,
    input  logic [LEN_W-1:0] req_len_i,
    output logic             busy_o,
    input  logic [7:0]       wd_data_i,
    input  logic             wd_valid_i,
    output logic             wd_ready_o,
    output logic [7:0]       rd_data_o,
    output logic             rd_valid_o,
    output logic             done_o,
    output logic             error_o,
    output logic             eng_go,
    output logic [1:0]       eng_op,
    output logic             eng_start,
    output logic             eng_stop,
    output logic             eng_nack,
    output logic [7:0]       eng_byte,
    input  logic             eng_done,
    input  logic             eng_ack,
    input  logic [7:0]       eng_rxbyte
);

    localparam int CK_W = $clog2(CHUNK_MAX + 1);
    localparam int BW_W = $clog2(BUF_WAIT + 1);
    localparam int PW_W = $clog2(POLL_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        seq_ph_e          ph;
        logic             write;
        logic             legacy;
        logic [6:0]       dev;
        logic [7:0]       off;
        logic [LEN_W-1:0] left;
        logic [CK_W-1:0]  chunk_left;
        logic             err;
        eng_cmd_t         cmd;
        logic             go;
        logic [7:0]       rdat;
        logic             rvld;
        logic             done;
        logic             error;
    } seq_regs_t;

    seq_regs_t q, d;
    eng_cmd_t  cmd_c;

    logic [LEN_W-1:0] sel_left;
    logic [CK_W-1:0]  sel_chunk;
    logic             t_load, t_dec, p_load, p_dec;
    logic [BW_W-1:0]  t_cnt;
    logic [PW_W-1:0]  p_cnt;

    assign sel_left = (q.st == ST_IDLE) ? req_len_i : q.left;

    xfer_chunk_sel #(
        .LEN_W     (LEN_W),
        .CHUNK_MAX (CHUNK_MAX),
        .CK_W      (CK_W)
    ) u_chunk (
        .left_i  (sel_left),
        .chunk_o (sel_chunk)
    );

    xfer_downcnt #(.W(BW_W)) u_gap_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (BW_W'(BUF_WAIT)),
        .dec_i      (t_dec),
        .cnt_o      (t_cnt)
    );

    xfer_downcnt #(.W(PW_W)) u_poll_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (p_load),
        .load_val_i (PW_W'(POLL_MAX)),
        .dec_i      (p_dec),
        .cnt_o      (p_cnt)
    );

    // command fields for the current phase
    always_comb begin
        cmd_c    = '0;
        cmd_c.op = ENG_WR;
        case (q.ph)
            PH_LEG: begin
                cmd_c.start = 1'b1;
                cmd_c.data  = {q.off[6:0], ~q.write};
            end
            PH_DEVW: begin
                cmd_c.start = 1'b1;
                cmd_c.data  = {q.dev, 1'b0};
            end
            PH_OFFS: cmd_c.data = q.off;
            PH_DEVR, PH_POLL: begin
                cmd_c.start = 1'b1;
                cmd_c.data  = {q.dev, 1'b1};
            end
            PH_RDAT: begin
                cmd_c.op   = ENG_RD;
                cmd_c.nack = (q.left == LEN_W'(1));
                cmd_c.stop = (q.left == LEN_W'(1));
            end
            PH_WDAT: begin
                cmd_c.data = wd_data_i;
                cmd_c.stop = (q.chunk_left == CK_W'(1));
            end
            PH_DUMMY: begin
                cmd_c.op   = ENG_RD;
                cmd_c.nack = 1'b1;
                cmd_c.stop = 1'b1;
            end
            PH_ABORT: cmd_c.op = ENG_STOP;
            default: ;
        endcase
    end

    always_comb begin
        d       = q;
        d.go    = 1'b0;
        d.rvld  = 1'b0;
        d.done  = 1'b0;
        d.error = 1'b0;
        t_load  = 1'b0;
        t_dec   = 1'b0;
        p_load  = 1'b0;
        p_dec   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.write      = req_write_i;
                    d.legacy     = req_legacy_i;
                    d.dev        = req_dev_i;
                    d.off        = req_offset_i;
                    d.left       = req_len_i;
                    d.chunk_left = sel_chunk;
                    d.err        = 1'b0;
                    d.ph         = req_legacy_i ? PH_LEG : PH_DEVW;
                    d.st         = (req_len_i == '0) ? ST_FIN : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (q.ph != PH_WDAT || wd_valid_i) begin
                    d.cmd = cmd_c;
                    d.go  = 1'b1;
                    d.st  = ST_WAIT;
                end
            end
            ST_GAP: begin
                if (t_cnt == '0) begin
                    d.st = ST_ISSUE;
                    d.ph = PH_DEVR;
                end else begin
                    t_dec = 1'b1;
                end
            end
            ST_FIN: begin
                d.done  = 1'b1;
                d.error = q.err;
                d.st    = ST_IDLE;
            end
            ST_WAIT: begin
                if (eng_done) begin
                    d.st = ST_ISSUE;
                    case (q.ph)
                        PH_LEG: begin
                            if (!eng_ack) begin
                                d.ph  = PH_ABORT;
                                d.err = 1'b1;
                            end else begin
                                d.ph = q.write ? PH_WDAT : PH_RDAT;
                            end
                        end
                        PH_DEVW: begin
                            if (!eng_ack) begin
                                d.ph  = PH_ABORT;
                                d.err = 1'b1;
                            end else begin
                                d.ph = PH_OFFS;
                            end
                        end
                        PH_OFFS: begin
                            if (!eng_ack) begin
                                d.ph  = PH_ABORT;
                                d.err = 1'b1;
                            end else if (q.write) begin
                                d.ph = PH_WDAT;
                            end else begin
                                d.st   = ST_GAP;
                                t_load = 1'b1;
                            end
                        end
                        PH_DEVR: begin
                            if (!eng_ack) begin
                                d.ph  = PH_ABORT;
                                d.err = 1'b1;
                            end else begin
                                d.ph = PH_RDAT;
                            end
                        end
                        PH_RDAT: begin
                            d.rvld = 1'b1;
                            d.rdat = eng_rxbyte;
                            d.left = q.left - LEN_W'(1);
                            if (q.left == LEN_W'(1))
                                d.st = ST_FIN;
                        end
                        PH_WDAT: begin
                            if (!eng_ack) begin
                                d.ph  = PH_ABORT;
                                d.err = 1'b1;
                            end else begin
                                d.left       = q.left - LEN_W'(1);
                                d.chunk_left = q.chunk_left - CK_W'(1);
                                d.off        = q.off + 8'd1;
                                if (q.chunk_left == CK_W'(1)) begin
                                    d.ph   = PH_POLL;
                                    p_load = 1'b1;
                                end
                            end
                        end
                        PH_POLL: begin
                            if (eng_ack) begin
                                d.ph = PH_DUMMY;
                            end else begin
                                p_dec = 1'b1;
                                if (p_cnt == PW_W'(1)) begin
                                    d.ph  = PH_ABORT;
                                    d.err = 1'b1;
                                end
                            end
                        end
                        PH_DUMMY: begin
                            if (q.left == '0) begin
                                d.st = ST_FIN;
                            end else begin
                                d.chunk_left = sel_chunk;
                                d.ph         = q.legacy ? PH_LEG : PH_DEVW;
                            end
                        end
                        PH_ABORT: d.st = ST_FIN;
                        default:  d.st = ST_FIN;
                    endcase
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign wd_ready_o = (q.st == ST_ISSUE) && (q.ph == PH_WDAT);
    assign rd_data_o  = q.rdat;
    assign rd_valid_o = q.rvld;
    assign done_o     = q.done;
    assign error_o    = q.error;
    assign eng_go     = q.go;
    assign eng_op     = q.cmd.op;
    assign eng_start  = q.cmd.start;
    assign eng_stop   = q.cmd.stop;
    assign eng_nack   = q.cmd.nack;
    assign eng_byte   = q.cmd.data;

    // R12
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAIT && !eng_done) |=> ($stable(eng_byte) && $stable(eng_op) && !eng_go));

    // R11
    err_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    // R11
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o) |-> (eng_op == ENG_STOP));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    wd_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready_o |-> q.write);

    // R6
    rd_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !q.write);

endmodule

// File: tb/eeprom_xfer_seq_test.sv
module eeprom_xfer_seq_test;

    localparam int LEN_W = 8;
    localparam int CH    = 4;
    localparam int BW    = 6;
    localparam int PM    = 4;
    localparam int LAT   = 3;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_legacy = 1'b0;
    logic [6:0] req_dev = DEV;
    logic [7:0] req_offset = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic busy, wd_ready, rd_valid, done, error;
    logic [7:0] wd_data;
    logic wd_valid = 1'b1;
    logic [7:0] rd_data;
    logic eng_go, eng_start, eng_stop, eng_nack;
    logic [1:0] eng_op;
    logic [7:0] eng_byte;
    logic eng_done = 1'b0, eng_ack = 1'b0;
    logic [7:0] eng_rxbyte = '0;

    eeprom_xfer_seq #(.LEN_W(LEN_W), .CHUNK_MAX(CH), .BUF_WAIT(BW), .POLL_MAX(PM)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_legacy_i(req_legacy),
        .req_dev_i(req_dev), .req_offset_i(req_offset), .req_len_i(req_len),
        .busy_o(busy), .wd_data_i(wd_data), .wd_valid_i(wd_valid), .wd_ready_o(wd_ready),
        .rd_data_o(rd_data), .rd_valid_o(rd_valid), .done_o(done), .error_o(error),
        .eng_go(eng_go), .eng_op(eng_op), .eng_start(eng_start), .eng_stop(eng_stop),
        .eng_nack(eng_nack), .eng_byte(eng_byte), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rxbyte(eng_rxbyte)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;

    logic [12:0] got [0:63];
    int go_t [0:63];
    int done_t [0:63];
    logic [12:0] ex [0:63];
    int ex_n, cmd_cnt, nack_idx, busy_n, poll_seen, rd_issued, r12_viol;
    bit txn_write, exp_err;
    logic [7:0] rd_got [0:63];
    int rd_cnt, wd_idx;
    bit wd_pend;

    assign wd_data = 8'(8'h30 + wd_idx);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // byte-engine responder
    initial begin
        logic [12:0] ent;
        bit a;
        logic [7:0] rx;
        forever begin
            @(negedge clk);
            if (eng_go) begin
                ent = {eng_op, eng_start, eng_stop, eng_nack, eng_byte};
                if (cmd_cnt < 64) begin
                    got[cmd_cnt]  = ent;
                    go_t[cmd_cnt] = cyc;
                end
                a = 1'b1;
                if (cmd_cnt == nack_idx) a = 1'b0;
                if (eng_op == 2'd0 && eng_start && eng_byte[0] && txn_write) begin
                    if (poll_seen < busy_n) begin
                        a = 1'b0;
                        poll_seen++;
                    end
                end else begin
                    poll_seen = 0;
                end
                rx = 8'(8'h5A + rd_issued);
                if (eng_op == 2'd1) rd_issued++;
                repeat (LAT - 1) begin
                    @(negedge clk);
                    if (eng_go) r12_viol++;
                end
                eng_done   = 1'b1;
                eng_ack    = a;
                eng_rxbyte = rx;
                if (cmd_cnt < 64) done_t[cmd_cnt] = cyc;
                cmd_cnt++;
                @(negedge clk);
                eng_done = 1'b0;
                if (eng_go) r12_viol++;
            end
        end
    end

    // stream monitor
    always @(negedge clk) begin
        if (wd_pend) begin
            wd_idx  = wd_idx + 1;
            wd_pend = 1'b0;
        end
        if (wd_ready) wd_pend = 1'b1;
        if (rd_valid) begin
            if (rd_cnt < 64) rd_got[rd_cnt] = rd_data;
            rd_cnt = rd_cnt + 1;
        end
    end

    task automatic push(input logic [1:0] op, input bit s, input bit p, input bit n,
                        input logic [7:0] b);
        ex[ex_n] = {op, s, p, n, b};
        ex_n++;
    endtask

    function automatic logic [12:0] msk(input logic [12:0] e);
        if (e[12:11] != 2'd0) return {e[12:8], 8'h00};
        return e;
    endfunction

    task automatic build(input bit w, input bit lg, input int off, input int len,
                         input int busyc, input int nk);
        int dn, c, o;
        bit stopped;
        ex_n = 0;
        exp_err = 1'b0;
        if (len > 0) begin
            if (!w) begin
                if (lg) push(2'd0, 1, 0, 0, {off[6:0], 1'b1});
                else begin
                    push(2'd0, 1, 0, 0, {DEV, 1'b0});
                    push(2'd0, 0, 0, 0, off[7:0]);
                    push(2'd0, 1, 0, 0, {DEV, 1'b1});
                end
                for (int k = 0; k < len; k++) push(2'd1, 0, k == len-1, k == len-1, 8'h00);
            end else begin
                dn = 0;
                stopped = 1'b0;
                while (dn < len && !stopped) begin
                    c = (len - dn > CH) ? CH : len - dn;
                    o = off + dn;
                    if (lg) push(2'd0, 1, 0, 0, {o[6:0], 1'b0});
                    else begin
                        push(2'd0, 1, 0, 0, {DEV, 1'b0});
                        push(2'd0, 0, 0, 0, o[7:0]);
                    end
                    for (int k = 0; k < c; k++) push(2'd0, 0, k == c-1, 0, 8'(8'h30 + dn + k));
                    if (busyc >= PM) begin
                        for (int k = 0; k < PM; k++) push(2'd0, 1, 0, 0, {DEV, 1'b1});
                        push(2'd2, 0, 0, 0, 8'h00);
                        exp_err = 1'b1;
                        stopped = 1'b1;
                    end else begin
                        for (int k = 0; k <= busyc; k++) push(2'd0, 1, 0, 0, {DEV, 1'b1});
                        push(2'd1, 0, 1, 1, 8'h00);
                    end
                    dn += c;
                end
            end
            if (nk >= 0) begin
                ex_n = nk + 1;
                push(2'd2, 0, 0, 0, 8'h00);
                exp_err = 1'b1;
            end
        end
    endtask

    task automatic run(input bit w, input bit lg, input int off, input int len,
                       input int busyc, input int nk, input string tag);
        int t, mism, nrd;
        bit e;
        build(w, lg, off, len, busyc, nk);
        cmd_cnt = 0; rd_cnt = 0; wd_idx = 0; wd_pend = 1'b0; rd_issued = 0; poll_seen = 0;
        nack_idx = nk; busy_n = busyc; txn_write = w;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_legacy = lg;
        req_offset = off[7:0]; req_len = len[LEN_W-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        e = error;
        chk(t < 3000, tag, "done seen", t, 0);
        mism = -1;
        for (int i = 0; i < ex_n && i < cmd_cnt; i++)
            if (mism < 0 && msk(got[i]) != msk(ex[i])) mism = i;
        if (cmd_cnt != ex_n) chk(1'b0, tag, "command count", cmd_cnt, ex_n);
        else if (mism >= 0) chk(1'b0, tag, $sformatf("command %0d", mism), got[mism], ex[mism]);
        else chk(1'b1, tag, "sequence", 0, 0);
        // R11 R10 R9 error flag
        chk(e == exp_err, exp_err ? "R11" : tag, "error flag", e, exp_err);
        nrd = 0;
        if (!w) for (int i = 0; i < ex_n; i++) if (ex[i][12:11] == 2'd1) nrd++;
        // R6 read stream, R8 dummy read hidden
        chk(rd_cnt == nrd, w ? "R8" : "R6", "read byte count", rd_cnt, nrd);
        for (int i = 0; i < nrd && i < rd_cnt; i++)
            if (rd_got[i] != 8'(8'h5A + i)) chk(1'b0, "R6", "read data", rd_got[i], 8'(8'h5A + i));
        // R4 bus-free gap before repeated START
        if (!w && !lg && len > 0 && (nk < 0 || nk > 1) && cmd_cnt > 2)
            chk(go_t[2] - done_t[1] >= BW, "R4", "gap cycles", go_t[2] - done_t[1], BW);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
    end

    initial begin
        cmd_cnt = 0; nack_idx = -1; busy_n = 0; poll_seen = 0; rd_issued = 0;
        r12_viol = 0; rd_cnt = 0; wd_idx = 0; wd_pend = 1'b0; txn_write = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, error, rd_valid, wd_ready, eng_go} == 6'b0, "R1", "reset outputs",
            {busy, done, error, rd_valid, wd_ready, eng_go}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, eng_go} == 3'b0, "R1", "idle after reset", {busy, done, eng_go}, 0);

        // R2 zero length, R3 R5 reads, R7 writes
        for (int len = 0; len < 10; len++) begin
            run(0, 0, 8'h10 + len * 3, len, 0, -1, len == 0 ? "R2" : "R3");
            run(0, 1, 8'h05 + len, len, 0, -1, len == 0 ? "R2" : "R5");
            run(1, 0, 8'h20 + len * 5, len, 0, -1, len == 0 ? "R2" : "R7");
            run(1, 1, 8'h07 + len, len, 0, -1, len == 0 ? "R2" : "R7");
        end
        // R7 offset wrap across chunks
        run(1, 0, 8'hFE, 6, 0, -1, "R7");
        // R8 several busy probes per chunk
        run(1, 0, 8'h40, 6, 2, -1, "R8");
        run(1, 1, 8'h11, 5, 1, -1, "R8");
        // R9 ack on the last permitted probe, then budget exhausted
        run(1, 0, 8'h33, 2, PM - 1, -1, "R9");
        run(1, 0, 8'h33, 2, PM, -1, "R9");
        run(1, 1, 8'h02, 6, PM, -1, "R9");
        // R10 missing acknowledge on address, offset, repeated START, data
        run(0, 0, 8'h50, 3, 0, 0, "R10");
        run(0, 0, 8'h50, 3, 0, 1, "R10");
        run(0, 0, 8'h50, 3, 0, 2, "R10");
        run(0, 1, 8'h12, 3, 0, 0, "R10");
        run(1, 0, 8'h60, 5, 0, 1, "R10");
        run(1, 0, 8'h60, 5, 0, 3, "R10");
        run(1, 1, 8'h08, 3, 0, 2, "R10");

        // R12 no command issued while the engine is busy
        chk(r12_viol == 0, "R12", "go during busy engine", r12_viol, 0);
        report();
    end

endmodule